// File: doc/BRIEF.md
# Serial Channel/Phase Capture Selector

This block sits behind the serial output of a two-channel digital downconverter. The converter sends one bit per clock. Its output is a repeating group of four 24-bit words that holds the in-phase (I) and quadrature (Q) samples of both channels. A one-cycle marker flags the first bit of a group. The block turns the bit stream back into words and labels each word with its position in the group. It keeps only the words of the channel and phase that the user picked, and presents each kept word on a synchronous write port to an external sample memory.

Software picks a channel and one of four phase modes, then pulses start. The block stores words at consecutive addresses until the memory is full. It then raises done and stops writing. In the two alternating modes the I and Q words take turns, so each phase fills half of the memory. The memory depth is a parameter; its default is 32768 words.

Top module: `chphase_capture`

## Requirements
- R1: Words are WORD_W bits, sent most significant bit first. A word starts on the bit that arrives while `ser_first_i` is high. No word is produced before the first marker.
- R2: Each word carries a slot index. Slot 0 is channel 0 I, slot 1 is channel 0 Q, slot 2 is channel 1 I and slot 3 is channel 1 Q. A marker resets the index to 0. Without a marker the index wraps from 3 back to 0. A marker in the middle of a word throws away the partial word.
- R3: Only words whose slot bit 1 equals the selected channel are stored.
- R4: The `phase_mode_i` encoding is: 0 stores I words (slot bit 0 = 0) only, 1 stores Q words (slot bit 0 = 1) only, 2 alternates I then Q, and 3 alternates Q then I.
- R5: In an alternating mode, storing starts only on a word of the phase that comes first in that mode. After that, the stored words strictly alternate between the two phases.
- R6: For each stored word, `mem_we_o` is high for exactly one cycle and `mem_data_o` carries the word. `mem_addr_o` is 0 for the first word after start and goes up by one for each later word.
- R7: `done_o` rises in the same cycle as the write to the last address, 2^ADDR_W-1. Nothing more is written until the next accepted start.
- R8: `busy_o` goes high in the cycle after an accepted start and falls in the same cycle that `done_o` rises. A start that arrives while busy is ignored.
- R9: The channel and phase mode are sampled when a start is accepted. Changing them during a capture has no effect.
- R10: After reset, `busy_o`, `done_o` and `mem_we_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit_i | input | 1 | Serial data bit |
| ser_first_i | input | 1 | High while the first bit of a group is on `ser_bit_i` |
| chan_sel_i | input | 1 | Channel to capture |
| phase_mode_i | input | 2 | Phase mode, encoded as in R4 |
| start_i | input | 1 | Start pulse |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_data_o | output | WORD_W | Memory write data |
| done_o | output | 1 | Memory full; held until the next start |
| busy_o | output | 1 | Capture in progress |

## Verification
The assertions check the following on every cycle:
- Busy and done are never high together.
- Done rises only together with the write to the last address.
- A write always follows a deframed word.
- Consecutive stores in an alternating mode carry opposite phases.
- A start that arrives while busy does not move the address.

Only the bench scenarios can show the rest. These are the exact words and addresses stored for each channel and mode, and where an alternating capture begins when start falls on the wrong phase. They also cover discarding a partial word at a mid-word marker, and ignoring a configuration change during a capture.

// File: rtl/capsel_pkg.sv
package capsel_pkg;

   typedef enum logic [1:0] {
      PH_I_ONLY = 2'd0,
      PH_Q_ONLY = 2'd1,
      PH_ALT_IQ = 2'd2,
      PH_ALT_QI = 2'd3
   } phase_mode_e;

   localparam int unsigned SLOT_W = 2;

   typedef struct packed {
      logic        chan;
      phase_mode_e mode;
   } capture_cfg_t;

endpackage

// File: rtl/capsel_deser.sv
module capsel_deser #(
   parameter int unsigned WORD_W    = 24,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         ser_bit_i,
   input  logic                         ser_first_i,
   output logic                         word_valid_o,
   output logic [WORD_W-1:0]            word_o,
   output logic [capsel_pkg::SLOT_W-1:0] slot_o
);
   localparam int unsigned CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
   localparam int unsigned SW    = capsel_pkg::SLOT_W;

   if (WORD_W < 2) begin : g_bad_width
      $error("capsel_deser: WORD_W must be at least 2");
   end

   logic [WORD_W-1:0] shreg_q, shifted;
   logic [CNT_W-1:0]  bit_cnt_q;
   logic [SW-1:0]     slot_q;
   logic              locked_q;
   logic              last_bit;

   // Bit order variant chosen at elaboration.
   if (MSB_FIRST) begin : g_msb
      assign shifted = {shreg_q[WORD_W-2:0], ser_bit_i};
   end else begin : g_lsb
      assign shifted = {ser_bit_i, shreg_q[WORD_W-1:1]};
   end

   assign last_bit = (bit_cnt_q == CNT_W'(WORD_W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg_q      <= '0;
         bit_cnt_q    <= '0;
         slot_q       <= '0;
         locked_q     <= 1'b0;
         word_valid_o <= 1'b0;
         word_o       <= '0;
         slot_o       <= '0;
      end else begin
         word_valid_o <= 1'b0;
         shreg_q      <= shifted;
         if (ser_first_i) begin
            locked_q  <= 1'b1;
            slot_q    <= '0;
            bit_cnt_q <= CNT_W'(1);
         end else if (locked_q) begin
            if (last_bit) begin
               bit_cnt_q    <= '0;
               word_valid_o <= 1'b1;
               word_o       <= shifted;
               slot_o       <= slot_q;
               slot_q       <= slot_q + 1'b1;
            end else begin
               bit_cnt_q <= bit_cnt_q + 1'b1;
            end
         end
      end
   end

   // R1
   word_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |=> !word_valid_o);
   // R1
   word_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> locked_q);

endmodule

// File: rtl/capsel_filter.sv
module capsel_filter
   import capsel_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_valid_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  capture_cfg_t      cfg_i,
   input  logic              arm_i,
   input  phase_mode_e       arm_mode_i,
   input  logic              busy_i,
   output logic              store_o
);
   logic ph_exp_q;
   logic chan_hit, phase_hit;
   logic word_ph;

   assign word_ph  = slot_i[0];
   assign chan_hit = (slot_i[1] == cfg_i.chan);

   always_comb begin
      unique case (cfg_i.mode)
         PH_I_ONLY: phase_hit = !word_ph;
         PH_Q_ONLY: phase_hit = word_ph;
         default:   phase_hit = (word_ph == ph_exp_q);
      endcase
   end

   assign store_o = word_valid_i && busy_i && chan_hit && phase_hit;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_exp_q <= 1'b0;
      end else if (arm_i) begin
         ph_exp_q <= (arm_mode_i == PH_ALT_QI);
      end else if (store_o) begin
         ph_exp_q <= !ph_exp_q;
      end
   end

   // Checker state: phase of the previous store in this capture.
   logic last_ph_q, have_prev_q;
   always_ff @(posedge clk) begin
      if (!rst_n || arm_i) begin
         last_ph_q   <= 1'b0;
         have_prev_q <= 1'b0;
      end else if (store_o) begin
         last_ph_q   <= word_ph;
         have_prev_q <= 1'b1;
      end
   end

   // R5
   alt_phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      store_o && cfg_i.mode[1] && have_prev_q |-> word_ph != last_ph_q);

endmodule

// File: rtl/capsel_ctrl.sv
module capsel_ctrl
   import capsel_pkg::*;
#(
   parameter int unsigned WORD_W = 24,
   parameter int unsigned ADDR_W = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  capture_cfg_t      cfg_in_i,
   input  logic              store_i,
   input  logic [WORD_W-1:0] word_i,
   output logic              arm_o,
   output capture_cfg_t      cfg_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0] mem_data_o
);
   localparam logic [ADDR_W-1:0] ADDR_LAST = {ADDR_W{1'b1}};

   if (ADDR_W < 1 || ADDR_W > 24) begin : g_bad_addr
      $error("capsel_ctrl: ADDR_W out of range");
   end

   logic [ADDR_W-1:0] addr_q;

   assign arm_o = start_i && !busy_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o     <= 1'b0;
         done_o     <= 1'b0;
         addr_q     <= '0;
         cfg_o      <= '{chan: 1'b0, mode: PH_I_ONLY};
         mem_we_o   <= 1'b0;
         mem_addr_o <= '0;
         mem_data_o <= '0;
      end else begin
         mem_we_o <= 1'b0;
         if (arm_o) begin
            busy_o <= 1'b1;
            done_o <= 1'b0;
            addr_q <= '0;
            cfg_o  <= cfg_in_i;
         end else if (store_i) begin
            mem_we_o   <= 1'b1;
            mem_addr_o <= addr_q;
            mem_data_o <= word_i;
            addr_q     <= addr_q + 1'b1;
            if (addr_q == ADDR_LAST) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   // R8
   busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));
   // R7
   done_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> mem_we_o && mem_addr_o == ADDR_LAST);
   // R8
   start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && start_i && !store_i |=> $stable(addr_q) && busy_o);

endmodule

// File: rtl/chphase_capture.sv
module chphase_capture
   import capsel_pkg::*;
#(
   parameter int unsigned WORD_W    = 24,
   parameter int unsigned ADDR_W    = 15,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ser_bit_i,
   input  logic              ser_first_i,
   input  logic              chan_sel_i,
   input  logic [1:0]        phase_mode_i,
   input  logic              start_i,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [WORD_W-1:0] mem_data_o,
   output logic              done_o,
   output logic              busy_o
);
   logic              word_valid;
   logic [WORD_W-1:0] word;
   logic [SLOT_W-1:0] slot;
   logic              store, arm;
   capture_cfg_t      cfg_in, cfg_live;

   assign cfg_in = '{chan: chan_sel_i, mode: phase_mode_e'(phase_mode_i)};

   capsel_deser #(.WORD_W(WORD_W), .MSB_FIRST(MSB_FIRST)) deser_i (
      .clk(clk), .rst_n(rst_n),
      .ser_bit_i(ser_bit_i), .ser_first_i(ser_first_i),
      .word_valid_o(word_valid), .word_o(word), .slot_o(slot)
   );

   capsel_filter filter_i (
      .clk(clk), .rst_n(rst_n),
      .word_valid_i(word_valid), .slot_i(slot), .cfg_i(cfg_live),
      .arm_i(arm), .arm_mode_i(cfg_in.mode), .busy_i(busy_o),
      .store_o(store)
   );

   capsel_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) ctrl_i (
      .clk(clk), .rst_n(rst_n),
      .start_i(start_i), .cfg_in_i(cfg_in), .store_i(store), .word_i(word),
      .arm_o(arm), .cfg_o(cfg_live), .busy_o(busy_o), .done_o(done_o),
      .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o)
   );

   // R6
   write_follows_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $past(word_valid));

endmodule

// File: tb/chphase_capture_tb_top.sv
module chphase_capture_tb_top;
   localparam int W  = 24;
   localparam int AW = 5;
   localparam int DEPTH = 1 << AW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ser_bit = 1'b0, ser_first = 1'b0, chan_sel = 1'b0, start = 1'b0;
   logic [1:0] pmode = 2'd0;
   logic mem_we, done, busy;
   logic [AW-1:0] mem_addr;
   logic [W-1:0] mem_data;

   chphase_capture #(.WORD_W(W), .ADDR_W(AW), .MSB_FIRST(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .ser_bit_i(ser_bit), .ser_first_i(ser_first),
      .chan_sel_i(chan_sel), .phase_mode_i(pmode), .start_i(start),
      .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_data_o(mem_data),
      .done_o(done), .busy_o(busy)
   );

   always #4 clk = ~clk;

   int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
   bit finished = 0;

   // Bench model
   bit m_busy = 0, m_done = 0, m_chan = 0, m_ph = 0;
   int m_mode = 0, m_addr = 0, m_slot = 0;
   logic [AW-1:0] exp_addr [0:1023];
   logic [W-1:0]  exp_data [0:1023];
   int wr_idx = 0, rd_idx = 0;

   function automatic bit phase_ok(int mode, int slot, bit exp_ph);
      bit ph = slot[0];
      case (mode)
         0: return !ph;
         1: return ph;
         default: return ph == exp_ph;
      endcase
   endfunction

   task automatic model_start(bit ch, int mode);
      if (!m_busy) begin
         m_busy = 1; m_done = 0; m_addr = 0;
         m_chan = ch; m_mode = mode; m_ph = (mode == 3);
      end
   endtask

   task automatic model_word(logic [W-1:0] d);
      int s = m_slot;
      m_slot = (m_slot + 1) % 4;
      if (m_busy && (s[1] == m_chan) && phase_ok(m_mode, s, m_ph)) begin
         exp_addr[wr_idx] = AW'(m_addr);
         exp_data[wr_idx] = d;
         wr_idx++;
         m_ph = !m_ph;
         m_addr++;
         if (m_addr == DEPTH) begin m_busy = 0; m_done = 1; end
      end
   endtask

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // Monitor: R6 write port order, address, data
   always @(negedge clk) begin
      if (rst_n && mem_we) begin
         mon_checks++;
         if (rd_idx >= wr_idx) begin
            mon_fails++;
            $display("FAIL R7 unexpected write actual addr=%0d expected=none", mem_addr);
         end else begin
            if (mem_addr !== exp_addr[rd_idx] || mem_data !== exp_data[rd_idx]) begin
               mon_fails++;
               $display("FAIL R6 actual addr=%0d data=%0h expected addr=%0d data=%0h",
                        mem_addr, mem_data, exp_addr[rd_idx], exp_data[rd_idx]);
            end
            rd_idx++;
         end
      end
   end

   // One word, MSB first (R1); marker and start on the first bit when asked.
   task automatic send_word(logic [W-1:0] d, bit first, bit st);
      if (first) m_slot = 0;
      if (st) model_start(chan_sel, int'(pmode));
      for (int i = W - 1; i >= 0; i--) begin
         @(negedge clk);
         ser_bit   = d[i];
         ser_first = first && (i == W - 1);
         start     = st && (i == W - 1);
      end
      model_word(d);
      @(negedge clk);
      ser_first = 0; start = 0;
      ser_bit = 1'b0;
      // the extra cycle above is bit 0 of a following word or a gap bit
      m_partial = 1;
   endtask

   bit m_partial = 0;

   // Frame of four words; start on slot st_slot (-1: none).
   task automatic send_frame(int st_slot);
      for (int k = 0; k < 4; k++) begin
         send_word_raw($urandom, (k == 0), (k == st_slot));
      end
   endtask

   // Back-to-back word sender (no trailing gap)
   task automatic send_word_raw(logic [W-1:0] d, bit first, bit st);
      if (first) m_slot = 0;
      if (st) model_start(chan_sel, int'(pmode));
      for (int i = W - 1; i >= 0; i--) begin
         @(negedge clk);
         ser_bit   = d[i];
         ser_first = first && (i == W - 1);
         start     = st && (i == W - 1);
      end
      model_word(d);
   endtask

   // Gap bits (fewer than a word); always followed by a marker.
   task automatic send_gap(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         ser_bit = 1'($urandom); ser_first = 0; start = 0;
      end
   endtask

   task automatic chk_status(string req);
      send_gap(3);
      check(busy === m_busy, req, busy, m_busy);
      check(done === m_done, req, done, m_done);
   endtask

   task automatic run_capture(bit ch, int mode, int st_slot);
      chan_sel = ch; pmode = 2'(mode);
      send_frame(st_slot);
      chk_status("R8");
      while (m_busy) send_frame(-1);
      chk_status("R7");
   endtask

   initial begin
      void'($urandom(32'd2024));
      repeat (4) @(negedge clk);
      // R10 reset state
      check(busy === 0, "R10", busy, 0);
      check(done === 0, "R10", done, 0);
      check(mem_we === 0, "R10", mem_we, 0);
      rst_n = 1;
      // R1: no words before first marker, even with start
      chan_sel = 0; pmode = 0;
      @(negedge clk); start = 1; model_start(0, 0);
      @(negedge clk); start = 0;
      send_gap(60);
      check(rd_idx == 0 && mem_we === 0, "R1", rd_idx, 0);
      check(busy === 1, "R8", busy, 1);
      // finish that capture: channel 0 I only (R3, R4)
      while (m_busy) send_frame(-1);
      chk_status("R7");
      // R7: nothing more written after done
      send_frame(-1); send_frame(-1);
      chk_status("R7");
      // R3/R4: channel 1, I only
      run_capture(1, 0, 0);
      // R4: channel 0, Q only
      run_capture(0, 1, 0);
      // R5: channel 1 alternating I first, start on ch1-Q -> skips to next ch1-I
      run_capture(1, 2, 3);
      // R5: channel 1 alternating Q first, start on ch1-Q -> begins at once
      run_capture(1, 3, 3);
      // R9 and R8: config change and restart while busy are ignored
      chan_sel = 0; pmode = 2'd3;
      send_frame(0);
      chan_sel = 1; pmode = 2'd0;
      send_frame(2);
      chk_status("R9");
      while (m_busy) send_frame(-1);
      chk_status("R9");
      // R2: continuous words, slot wraps without further markers
      chan_sel = 1; pmode = 2'd2;
      send_word_raw($urandom, 1, 1);
      for (int k = 0; k < 40; k++) send_word_raw($urandom, 0, 0);
      // R2/R1: marker mid-word drops the partial word
      send_gap(11);
      while (m_busy) send_frame(-1);
      chk_status("R2");
      // constrained random captures
      for (int r = 0; r < 4; r++) begin
         run_capture(1'($urandom), int'($urandom % 4), int'($urandom % 4));
         if (($urandom % 2) == 1) send_gap(int'($urandom % 20));
      end
      send_gap(4);
      check(rd_idx == wr_idx, "R6", rd_idx, wr_idx);
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", checks + mon_checks, fails + mon_fails);
      $finish;
   end

   initial begin
      #1400000;
      if (!finished) begin
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", checks + mon_checks + 1, fails + mon_fails);
         $finish;
      end
   end
endmodule